// File: doc/BRIEF.md
# Serial Control Register Bank

This block terminates a three-wire configuration port. A host lowers the enable line, clocks sixteen bits into the data line, and raises the enable line again. The first four bits carry a register address and the remaining twelve carry a data field; both are sent most significant bit first. On the enable rising edge the word is decoded into a set of parallel control registers: a gain code, an auxiliary converter code, a clamp reference code, a ten-bit control/polarity word and an extended-gain flag.

Gain, clamp reference and control word are double-buffered. A write lands in a staging copy and reaches the outputs on the next frame-sync edge. The control word itself chooses whether that edge is rising or falling. The auxiliary code and the extended-gain flag take effect as soon as the frame is accepted. An initialization address puts every register, staged or live, back to its default at once. If frame sync is tied to the enable line and the rising edge is selected, staged updates become visible as soon as the frame ends.

All four port inputs are oversampled in the system clock domain through two-flop synchronizers. Edges are detected on the synchronized levels.

Top module: `scp_serial_cfg`

## Requirements
- R1: A frame is 16 data-line samples taken on serial-clock rising edges while the enable line is low, most significant bit first: address bits [15:12], then data bits [11:0].
- R2: Address 0x0 stages data[7:0] as the gain code; `gain_code_o` keeps its old value until a commit edge.
- R3: Address 0x1 loads data[7:0] into `aux_code_o` directly, without waiting for frame sync.
- R4: Address 0x2 stages data[6:0] as the clamp reference (0 to 127); data[11:7] are ignored.
- R5: Address 0x3 stages data[9:0] as the control word; bit 8 of that word is the commit-edge select.
- R6: Address 0x4 loads data[7] into `gain_ext_o` directly.
- R7: Staged values are copied to the outputs on a frame-sync rising edge when bit 8 of the live control word is 0, and on a falling edge when it is 1. The other edge does nothing.
- R8: A frame with fewer or more than 16 serial-clock rising edges while enable is low changes no register.
- R9: Address 0xF immediately sets gain, aux and clamp to 0, extended gain to 0 and the control word to 0x100, in both staged and live copies.
- R10: Addresses 0x5 to 0xE change no register, staged or live.
- R11: After reset every output holds the value that R9 defines.
- R12: With frame sync tied to the enable line and bit 8 of the control word at 0, a staged write is live right after its own frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the port |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| sen_i | input | 1 | Frame enable, low during a frame |
| vsync_i | input | 1 | Frame sync used to commit staged values |
| gain_code_o | output | 8 | Live gain code |
| aux_code_o | output | 8 | Auxiliary converter code |
| clamp_ref_o | output | 7 | Live clamp reference code |
| ctrl_word_o | output | 10 | Live control/polarity word |
| gain_ext_o | output | 1 | Extended gain range enable |

## Verification
A table of frames first drives each address with data patterns whose high and low halves differ, such as 0x5A3 and 0xF7C. These patterns show whether bits are taken in the right order and from the right field, and whether out-of-field bits leak into the clamp and control registers. Each staged write is checked once before a sync pulse and once after it, which tells staging apart from a direct load. Directed cases then drive a lone rising and a lone falling sync edge under both settings of the edge-select bit, send 15-clock and 17-clock frames, write the reserved addresses, and send an initialization that arrives over a pending write. The last case ties frame sync to the enable line, first with the falling-edge default and then after switching to the rising edge.

// File: rtl/scp_pkg.sv
`timescale 1ns/1ps
package scp_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 12;
  localparam int FRAME_W  = ADDR_W + DATA_W;
  localparam int GAIN_W   = 8;
  localparam int AUX_W    = 8;
  localparam int CLAMP_W  = 7;
  localparam int CTRL_W   = 10;
  localparam int EDGE_BIT = 8;
  localparam int EXT_BIT  = 7;

  localparam logic [ADDR_W-1:0] ADDR_GAIN  = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_AUX   = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_CLAMP = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'h3;
  localparam logic [ADDR_W-1:0] ADDR_EXT   = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_INIT  = 4'hF;

  localparam logic [CTRL_W-1:0] CTRL_DEF = 10'h100;

  typedef struct packed {
    logic [GAIN_W-1:0]  gain;
    logic [CLAMP_W-1:0] clamp;
    logic [CTRL_W-1:0]  ctrl;
  } stage_t;

  localparam stage_t STAGE_DEF = '{gain: '0, clamp: '0, ctrl: CTRL_DEF};
endpackage

// File: rtl/scp_sync_edge.sv
`timescale 1ns/1ps
module scp_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic dly_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {(STAGES+1){RST_VAL}};
    else         q <= {q[STAGES-1:0], pin_i};
  end

  assign lvl_o = q[STAGES-1];
  assign dly_o = q[STAGES];
endmodule

// File: rtl/scp_shifter.sv
`timescale 1ns/1ps
module scp_shifter import scp_pkg::*; #(
  parameter int SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_lvl_i,
  input  logic              sclk_dly_i,
  input  logic              sen_lvl_i,
  input  logic              sen_dly_i,
  output logic              frame_vld_o,
  output logic [ADDR_W-1:0] frame_addr_o,
  output logic [CTRL_W-1:0] frame_dat_o
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [SYNC-1:0]    sd_q;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               sclk_rise, sen_rise;

  assign sclk_rise = sclk_lvl_i & ~sclk_dly_i;
  assign sen_rise  = sen_lvl_i & ~sen_dly_i;

  // data path gets the same synchronizer depth as the clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sd_q <= '0;
    else         sd_q <= {sd_q[SYNC-2:0], sdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (sen_lvl_i) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[FRAME_W-2:0], sd_q[SYNC-1]};
      // saturate so long frames never wrap back to a valid count
      if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
    end
  end

  assign frame_vld_o  = sen_rise && (cnt == CNT_W'(FRAME_W));
  assign frame_addr_o = shreg[FRAME_W-1 -: ADDR_W];
  assign frame_dat_o  = shreg[CTRL_W-1:0];
endmodule

// File: rtl/scp_regbank.sv
`timescale 1ns/1ps
module scp_regbank import scp_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_vld_i,
  input  logic [ADDR_W-1:0]  frame_addr_i,
  input  logic [CTRL_W-1:0]  frame_dat_i,
  input  logic               vs_lvl_i,
  input  logic               vs_dly_i,
  output logic               commit_o,
  output logic [GAIN_W-1:0]  gain_o,
  output logic [AUX_W-1:0]   aux_o,
  output logic [CLAMP_W-1:0] clamp_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               ext_o
);
  stage_t             stage_q, stage_nxt, act_q;
  logic [AUX_W-1:0]   aux_q;
  logic               ext_q;
  logic               wr_init, vs_rise, vs_fall;

  assign wr_init = frame_vld_i && (frame_addr_i == ADDR_INIT);
  assign vs_rise = vs_lvl_i & ~vs_dly_i;
  assign vs_fall = ~vs_lvl_i & vs_dly_i;
  assign commit_o = act_q.ctrl[EDGE_BIT] ? vs_fall : vs_rise;

  always_comb begin
    stage_nxt = stage_q;
    if (frame_vld_i) begin
      unique case (frame_addr_i)
        ADDR_GAIN:  stage_nxt.gain  = frame_dat_i[GAIN_W-1:0];
        ADDR_CLAMP: stage_nxt.clamp = frame_dat_i[CLAMP_W-1:0];
        ADDR_CTRL:  stage_nxt.ctrl  = frame_dat_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= STAGE_DEF;
      act_q   <= STAGE_DEF;
      aux_q   <= '0;
      ext_q   <= 1'b0;
    end else if (wr_init) begin
      stage_q <= STAGE_DEF;
      act_q   <= STAGE_DEF;
      aux_q   <= '0;
      ext_q   <= 1'b0;
    end else begin
      stage_q <= stage_nxt;
      // bypass: a frame and a commit in one cycle commit the new value
      if (commit_o) act_q <= stage_nxt;
      if (frame_vld_i && frame_addr_i == ADDR_AUX) aux_q <= frame_dat_i[AUX_W-1:0];
      if (frame_vld_i && frame_addr_i == ADDR_EXT) ext_q <= frame_dat_i[EXT_BIT];
    end
  end

  assign gain_o  = act_q.gain;
  assign clamp_o = act_q.clamp;
  assign ctrl_o  = act_q.ctrl;
  assign aux_o   = aux_q;
  assign ext_o   = ext_q;
endmodule

// File: rtl/scp_serial_cfg.sv
`timescale 1ns/1ps
module scp_serial_cfg import scp_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               sen_i,
  input  logic               vsync_i,
  output logic [GAIN_W-1:0]  gain_code_o,
  output logic [AUX_W-1:0]   aux_code_o,
  output logic [CLAMP_W-1:0] clamp_ref_o,
  output logic [CTRL_W-1:0]  ctrl_word_o,
  output logic               gain_ext_o
);
  localparam int N_PIN = 3;
  localparam logic [N_PIN-1:0] IDLE_LVL = 3'b010; // vsync, sen, sclk

  logic [N_PIN-1:0]  pin_w, lvl_w, dly_w;
  logic              frame_vld, commit;
  logic [ADDR_W-1:0] frame_addr;
  logic [CTRL_W-1:0] frame_dat;

  assign pin_w = {vsync_i, sen_i, sclk_i};

  for (genvar g = 0; g < N_PIN; g++) begin : g_sync
    scp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL[g])) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_w[g]),
      .lvl_o (lvl_w[g]),
      .dly_o (dly_w[g])
    );
  end

  scp_shifter #(.SYNC(SYNC_STAGES)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sdata_i     (sdata_i),
    .sclk_lvl_i  (lvl_w[0]),
    .sclk_dly_i  (dly_w[0]),
    .sen_lvl_i   (lvl_w[1]),
    .sen_dly_i   (dly_w[1]),
    .frame_vld_o (frame_vld),
    .frame_addr_o(frame_addr),
    .frame_dat_o (frame_dat)
  );

  scp_regbank i_regbank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld),
    .frame_addr_i(frame_addr),
    .frame_dat_i (frame_dat),
    .vs_lvl_i    (lvl_w[2]),
    .vs_dly_i    (dly_w[2]),
    .commit_o    (commit),
    .gain_o      (gain_code_o),
    .aux_o       (aux_code_o),
    .clamp_o     (clamp_ref_o),
    .ctrl_o      (ctrl_word_o),
    .ext_o       (gain_ext_o)
  );
endmodule

// File: rtl/scp_cfg_chk.sv
`timescale 1ns/1ps
module scp_cfg_chk import scp_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_vld_i,
  input logic [ADDR_W-1:0] frame_addr_i,
  input logic              commit_i,
  input logic [GAIN_W-1:0] gain_i,
  input logic [AUX_W-1:0]  aux_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              ext_i
);
  assert_aux_after_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(aux_i) |-> $past(frame_vld_i));

  assert_ext_after_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ext_i) |-> $past(frame_vld_i));

  assert_gain_needs_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_i) |-> $past(commit_i || frame_vld_i));

  assert_ctrl_needs_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_i) |-> $past(commit_i || frame_vld_i));

  assert_init_ctrl_default_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_vld_i && frame_addr_i == ADDR_INIT) |-> ctrl_i == CTRL_DEF);
endmodule

bind scp_serial_cfg scp_cfg_chk i_cfg_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_vld_i (frame_vld),
  .frame_addr_i(frame_addr),
  .commit_i    (commit),
  .gain_i      (gain_code_o),
  .aux_i       (aux_code_o),
  .ctrl_i      (ctrl_word_o),
  .ext_i       (gain_ext_o)
);

// File: tb/test_scp_serial_cfg.sv
`timescale 1ns/1ps
module test_scp_serial_cfg;
  localparam int HALF = 13;
  localparam int NVEC = 8;
  // {addr[31:28], data[27:16], sel[15:13], staged[12], exp[11:0]}
  // sel: 0 gain, 1 aux, 2 clamp, 3 ctrl, 4 ext
  localparam logic [31:0] VEC [NVEC] = '{
    {4'h0, 12'h5A3, 3'd0, 1'b1, 12'h0A3},
    {4'h1, 12'hF7C, 3'd1, 1'b0, 12'h07C},
    {4'h2, 12'hFFF, 3'd2, 1'b1, 12'h07F},
    {4'h2, 12'h080, 3'd2, 1'b1, 12'h000},
    {4'h3, 12'hEFF, 3'd3, 1'b1, 12'h2FF},
    {4'h4, 12'h080, 3'd4, 1'b0, 12'h001},
    {4'h4, 12'hF7F, 3'd4, 1'b0, 12'h000},
    {4'h0, 12'h0FF, 3'd0, 1'b1, 12'h0FF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_r = 1'b0, sdata_r = 1'b0, sen_r = 1'b1, vs_ind = 1'b0, tie = 1'b0;
  logic vsync_w;
  logic [7:0] gain, aux;
  logic [6:0] clamp;
  logic [9:0] ctrl;
  logic ext;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [11:0] act [5];

  always #2 clk = ~clk;
  assign vsync_w = tie ? sen_r : vs_ind;

  scp_serial_cfg i_scp_serial_cfg (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk_r), .sdata_i(sdata_r),
    .sen_i(sen_r), .vsync_i(vsync_w), .gain_code_o(gain), .aux_code_o(aux),
    .clamp_ref_o(clamp), .ctrl_word_o(ctrl), .gain_ext_o(ext)
  );

  function automatic logic [11:0] out_of(input logic [2:0] sel);
    case (sel)
      3'd0:    return {4'h0, gain};
      3'd1:    return {4'h0, aux};
      3'd2:    return {5'h0, clamp};
      3'd3:    return {2'h0, ctrl};
      default: return {11'h0, ext};
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] sel);
    case (sel)
      3'd0:    return "R2";
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [3:0] a, input logic [11:0] d, input int nclk);
    logic [15:0] w;
    w = {a, d};
    @(negedge clk) sen_r = 1'b0;
    idle(6);
    for (int i = 0; i < nclk; i++) begin
      sdata_r = (i < 16) ? w[15 - i] : 1'b0;
      idle(HALF);
      sclk_r = 1'b1;
      idle(HALF);
      sclk_r = 1'b0;
    end
    idle(6);
    sen_r = 1'b1;
    idle(12);
  endtask

  task automatic set_vs(input logic v);
    vs_ind = v;
    idle(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);
    // R11: reset state
    check("R11", {4'h0, gain}, 12'h000);
    check("R11", {4'h0, aux}, 12'h000);
    check("R11", {2'h0, ctrl}, 12'h100);
    check("R11", {5'h0, clamp} | {11'h0, ext}, 12'h000);
    act[0] = 12'h0; act[1] = 12'h0; act[2] = 12'h0; act[3] = 12'h100; act[4] = 12'h0;

    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][31:28], VEC[v][27:16], 16);
      if (VEC[v][12]) begin
        check(req_of(VEC[v][15:13]), out_of(VEC[v][15:13]), act[VEC[v][15:13]]);
        set_vs(1'b1);
        set_vs(1'b0);
      end
      act[VEC[v][15:13]] = VEC[v][11:0];
      check(req_of(VEC[v][15:13]), out_of(VEC[v][15:13]), VEC[v][11:0]);
      if (v == 1) check("R1", {4'h0, aux}, 12'h07C);
    end

    // R7: edge select, live SD8 is 0 here (rising)
    send_frame(4'h3, 12'h3D4, 16);
    set_vs(1'b1);
    check("R7", {2'h0, ctrl}, 12'h3D4);
    send_frame(4'h0, 12'h033, 16);
    set_vs(1'b0);
    check("R7", {4'h0, gain}, 12'h033);
    send_frame(4'h0, 12'h044, 16);
    set_vs(1'b1);
    check("R7", {4'h0, gain}, 12'h033);
    set_vs(1'b0);
    check("R7", {4'h0, gain}, 12'h044);

    // R8: wrong clock counts discarded
    send_frame(4'h1, 12'h0AA, 15);
    check("R8", {4'h0, aux}, 12'h07C);
    send_frame(4'h1, 12'h0AA, 17);
    check("R8", {4'h0, aux}, 12'h07C);

    // R10: reserved addresses
    send_frame(4'h7, 12'hFFF, 16);
    send_frame(4'hC, 12'hFFF, 16);
    check("R10", {4'h0, aux}, 12'h07C);
    check("R10", {11'h0, ext}, 12'h000);
    set_vs(1'b1);
    set_vs(1'b0);
    check("R10", {4'h0, gain}, 12'h044);
    check("R10", {5'h0, clamp}, 12'h000);
    check("R10", {2'h0, ctrl}, 12'h3D4);

    // R9: init over a pending staged gain
    send_frame(4'h6, 12'h000, 0);
    send_frame(4'h0, 12'h055, 16);
    send_frame(4'h4, 12'h080, 16);
    send_frame(4'hF, 12'h123, 16);
    check("R9", {4'h0, gain}, 12'h000);
    check("R9", {4'h0, aux}, 12'h000);
    check("R9", {2'h0, ctrl}, 12'h100);
    check("R9", {11'h0, ext}, 12'h000);
    set_vs(1'b1);
    set_vs(1'b0);
    check("R9", {4'h0, gain}, 12'h000);

    // R12: frame sync tied to enable
    tie = 1'b1;
    idle(10);
    send_frame(4'h3, 12'h204, 16);
    check("R12", {2'h0, ctrl}, 12'h100);
    send_frame(4'h0, 12'h066, 16);
    check("R12", {2'h0, ctrl}, 12'h204);
    check("R12", {4'h0, gain}, 12'h066);
    send_frame(4'h0, 12'h077, 16);
    check("R12", {4'h0, gain}, 12'h077);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule